// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block tracks eight prioritized interrupt lines and decides when the core should begin a new interrupt routine. Line 0 is the non-maskable line and a smaller line number always means a higher priority. The controller keeps three 8-bit level registers, each with a 3-bit level field in its low bits and zeros above it:
- the programmed mask, written by software through a write port;
- the effective mask;
- the current status level, which encodes the highest-priority active line.

A request for interrupt entry goes out when the status level beats the effective mask. When the core acknowledges the entry, the effective mask is raised to the level being serviced. After that, only a strictly higher-priority line can start a nested routine. A return-from-interrupt or clear-effective-mask strobe puts the effective mask back to the programmed mask, but only when the core is in hypervisor mode.

The incoming lines pass through a parameterised number of sampling stages before they are encoded. With the default of one stage, the status level and the request follow the lines one clock later. When no line is active, the status register shows a dedicated "none" code and a separate valid output is low, so this code is never confused with level 0.

Top module: `prio_irq_level_ctrl`

## Requirements
- R1: The status register `isr_reg` holds, in bits [2:0], the lowest-numbered line that was active at the previous clock edge, whether or not that line is masked, and bits [7:3] are zero. `isr_valid` is 1 whenever any line was active. For example, lines 2, 5 and 7 active give `isr_reg` = 2.
- R2: With no line active, `isr_valid` is 0, `isr_reg` reads 7 (the "none" code) and `entry_req` is 0.
- R3: After reset, `imr_reg` = 0 and `eim_reg` = 0, and the effective mask is in programmed mode. In that state every line except line 0 is disabled.
- R4: When `mask_wr_en` is high, `imr_reg` takes `mask_wr_data[2:0]` at the next edge and its bits [7:3] read zero. A mask write alone does not change `eim_reg`.
- R5: In programmed mode (after reset, or after a reload from the mask), `entry_req` is 1 exactly when `isr_valid` is 1 and the status level ≤ the effective level. As a result, line 0 is always enabled, and with a mask of 0 only line 0 is enabled.
- R6: On `entry_ack` with `isr_valid` high, `eim_reg` takes the current status level at the next edge and the effective mask enters serviced mode. In serviced mode, `entry_req` is 1 only when the status level is strictly less than the effective level.
- R7: `rti_strobe` or `cleim_strobe` with `hyper_mode` high reloads `eim_reg` from `imr_reg` at the next edge and returns to programmed mode. With `hyper_mode` low, these strobes have no effect.
- R8: When an acknowledge (with `isr_valid` high) and a hypervisor return or clear arrive in the same cycle, the acknowledge wins.
- R9: `entry_ack` while `isr_valid` is 0 leaves `eim_reg` and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Interrupt lines, bit n is line n, 1 = active |
| mask_wr_en | input | 1 | Write strobe for the programmed mask |
| mask_wr_data | input | 8 | Write data, bits [2:0] used |
| entry_ack | input | 1 | Core acknowledges interrupt entry |
| rti_strobe | input | 1 | Return from interrupt executed |
| cleim_strobe | input | 1 | Clear-effective-mask executed |
| hyper_mode | input | 1 | Core is in hypervisor mode |
| imr_reg | output | 8 | Programmed mask register |
| eim_reg | output | 8 | Effective mask register |
| isr_reg | output | 8 | Current status level register |
| isr_valid | output | 1 | At least one line active |
| entry_req | output | 1 | Request to start an interrupt routine |

## Verification
Two functions can land in the same cycle: an entry acknowledge and a hypervisor return or clear. Both rewrite the effective mask, and the acknowledge must win.

The bench provokes this collision with a directed case that raises both in one cycle with an active line. Random cycles also assert the strobes independently, so the collision recurs many times alongside mask writes and line changes. Each cycle is judged against a bench model that applies the acknowledge first. The model also ignores the return strobes outside hypervisor mode and compares the effective level, the status level and the request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // Mode of the effective mask: compared inclusively after a reload from
   // the programmed mask, strictly after an entry acknowledge.
   typedef enum logic {
      EIM_PROGRAMMED = 1'b0,
      EIM_SERVICED   = 1'b1
   } eim_mode_e;

   // Request decision shared by the comparator.
   function automatic logic level_beats(input int unsigned lvl,
                                        input int unsigned eff,
                                        input eim_mode_e   mode);
      if (mode == EIM_PROGRAMMED) return (lvl <= eff);
      return (lvl < eff);
   endfunction
endpackage

// File: rtl/prio_irq_sampler.sv
module prio_irq_sampler #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned STAGES    = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_in,
   output logic [NUM_LINES-1:0] lines_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign lines_out = lines_in;
      end else begin : g_chain
         logic [NUM_LINES-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else if (s == 0) begin
                  stage_q[s] <= lines_in;
               end else begin
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign lines_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/prio_irq_encoder.sv
module prio_irq_encoder #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned LVL_W     = 3
) (
   input  logic [NUM_LINES-1:0] lines,
   output logic [LVL_W-1:0]     level,
   output logic                 valid
);
   localparam logic [LVL_W-1:0] NONE_CODE = '1;

   always_comb begin
      level = NONE_CODE;
      valid = 1'b0;
      for (int i = NUM_LINES-1; i >= 0; i--) begin
         if (lines[i]) begin
            level = LVL_W'(i);
            valid = 1'b1;
         end
      end
   end
endmodule

// File: rtl/prio_irq_mask_regs.sv
module prio_irq_mask_regs
   import prio_irq_pkg::*;
#(
   parameter int unsigned         LVL_W     = 3,
   parameter logic [LVL_W-1:0]    IMR_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LVL_W-1:0] wr_level,
   input  logic             ack,
   input  logic [LVL_W-1:0] cur_level,
   input  logic             cur_valid,
   input  logic             reload,
   output logic [LVL_W-1:0] imr_q,
   output logic [LVL_W-1:0] eim_q,
   output eim_mode_e        mode_q
);
   logic take_ack;
   assign take_ack = ack && cur_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q <= IMR_RESET;
      end else if (wr_en) begin
         imr_q <= wr_level;
      end
   end

   // Acknowledge has priority over a reload in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eim_q  <= IMR_RESET;
         mode_q <= EIM_PROGRAMMED;
      end else if (take_ack) begin
         eim_q  <= cur_level;
         mode_q <= EIM_SERVICED;
      end else if (reload) begin
         eim_q  <= imr_q;
         mode_q <= EIM_PROGRAMMED;
      end
   end
endmodule

// File: rtl/prio_irq_req_cmp.sv
module prio_irq_req_cmp
   import prio_irq_pkg::*;
#(
   parameter int unsigned LVL_W = 3
) (
   input  logic [LVL_W-1:0] cur_level,
   input  logic             cur_valid,
   input  logic [LVL_W-1:0] eim_level,
   input  eim_mode_e        mode,
   output logic             req
);
   always_comb begin
      req = cur_valid && level_beats(int'(cur_level), int'(eim_level), mode);
   end
endmodule

// File: rtl/prio_irq_level_ctrl.sv
module prio_irq_level_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 8,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 1,
   parameter int unsigned IMR_RESET   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 mask_wr_en,
   input  logic [REG_W-1:0]     mask_wr_data,
   input  logic                 entry_ack,
   input  logic                 rti_strobe,
   input  logic                 cleim_strobe,
   input  logic                 hyper_mode,
   output logic [REG_W-1:0]     imr_reg,
   output logic [REG_W-1:0]     eim_reg,
   output logic [REG_W-1:0]     isr_reg,
   output logic                 isr_valid,
   output logic                 entry_req
);
   localparam int unsigned LVL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int unsigned PAD_W = REG_W - LVL_W;

   initial begin
      if (NUM_LINES < 2) $error("NUM_LINES must be at least 2");
      if (LVL_W >= REG_W) $error("REG_W must exceed the level width");
      if (IMR_RESET >= NUM_LINES) $error("IMR_RESET out of range");
   end

   logic [NUM_LINES-1:0] lines_s;
   logic [LVL_W-1:0]     cur_level;
   logic                 cur_valid;
   logic [LVL_W-1:0]     imr_q;
   logic [LVL_W-1:0]     eim_q;
   eim_mode_e            mode_q;
   logic                 reload;

   assign reload = (rti_strobe || cleim_strobe) && hyper_mode;

   prio_irq_sampler #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .lines_in(irq_lines), .lines_out(lines_s)
   );

   prio_irq_encoder #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_encoder (
      .lines(lines_s), .level(cur_level), .valid(cur_valid)
   );

   prio_irq_mask_regs #(.LVL_W(LVL_W), .IMR_RESET(LVL_W'(IMR_RESET))) u_masks (
      .clk(clk), .rst_n(rst_n),
      .wr_en(mask_wr_en), .wr_level(mask_wr_data[LVL_W-1:0]),
      .ack(entry_ack), .cur_level(cur_level), .cur_valid(cur_valid),
      .reload(reload),
      .imr_q(imr_q), .eim_q(eim_q), .mode_q(mode_q)
   );

   prio_irq_req_cmp #(.LVL_W(LVL_W)) u_cmp (
      .cur_level(cur_level), .cur_valid(cur_valid),
      .eim_level(eim_q), .mode(mode_q), .req(entry_req)
   );

   assign imr_reg   = {{PAD_W{1'b0}}, imr_q};
   assign eim_reg   = {{PAD_W{1'b0}}, eim_q};
   assign isr_reg   = {{PAD_W{1'b0}}, cur_level};
   assign isr_valid = cur_valid;
endmodule

// File: rtl/prio_irq_level_checker.sv
module prio_irq_level_checker #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] mask_wr_data,
   input logic             mask_wr_en,
   input logic             entry_ack,
   input logic             rti_strobe,
   input logic             cleim_strobe,
   input logic             hyper_mode,
   input logic [REG_W-1:0] imr_reg,
   input logic [REG_W-1:0] eim_reg,
   input logic [REG_W-1:0] isr_reg,
   input logic             isr_valid,
   input logic             entry_req
);
   p_none_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !isr_valid |-> !entry_req);

   p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_en |=> imr_reg == {5'b0, $past(mask_wr_data[2:0])});

   p_ack_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_ack && isr_valid) |=> eim_reg == $past(isr_reg));

   p_serviced_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_ack && isr_valid) |=> (isr_reg == eim_reg) -> !entry_req);

   p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((rti_strobe || cleim_strobe) && hyper_mode && !(entry_ack && isr_valid))
      |=> eim_reg == $past(imr_reg));

   p_user_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hyper_mode && !(entry_ack && isr_valid)) |=> $stable(eim_reg));

   p_ack_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_ack && isr_valid && rti_strobe && hyper_mode)
      |=> eim_reg == $past(isr_reg));
endmodule

bind prio_irq_level_ctrl prio_irq_level_checker #(.REG_W(REG_W)) u_checker (
   .clk(clk), .rst_n(rst_n), .mask_wr_data(mask_wr_data), .mask_wr_en(mask_wr_en),
   .entry_ack(entry_ack), .rti_strobe(rti_strobe), .cleim_strobe(cleim_strobe),
   .hyper_mode(hyper_mode), .imr_reg(imr_reg), .eim_reg(eim_reg),
   .isr_reg(isr_reg), .isr_valid(isr_valid), .entry_req(entry_req)
);

// File: tb/prio_irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_level_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_lines = '0;
   logic       mask_wr_en = 1'b0;
   logic [7:0] mask_wr_data = '0;
   logic       entry_ack = 1'b0;
   logic       rti_strobe = 1'b0;
   logic       cleim_strobe = 1'b0;
   logic       hyper_mode = 1'b0;
   logic [7:0] imr_reg, eim_reg, isr_reg;
   logic       isr_valid, entry_req;

   int checks = 0;
   int fails  = 0;

   // bench model state
   logic [7:0] m_lines = '0;
   int         m_imr = 0;
   int         m_eim = 0;
   bit         m_serviced = 0;

   always #4 clk = ~clk;

   prio_irq_level_ctrl u_prio_irq_level_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .entry_ack(entry_ack), .rti_strobe(rti_strobe), .cleim_strobe(cleim_strobe),
      .hyper_mode(hyper_mode), .imr_reg(imr_reg), .eim_reg(eim_reg),
      .isr_reg(isr_reg), .isr_valid(isr_valid), .entry_req(entry_req)
   );

   function automatic int f_level(input logic [7:0] l);
      for (int i = 0; i < 8; i++) if (l[i]) return i;
      return 7;
   endfunction

   function automatic bit f_req(input logic [7:0] l, input int eim, input bit serv);
      if (l == 0) return 0;
      if (serv) return f_level(l) < eim;
      return f_level(l) <= eim;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(req, "isr_reg", int'(isr_reg), f_level(m_lines));
      check(req, "isr_valid", int'(isr_valid), int'(m_lines != 0));
      check(req, "imr_reg", int'(imr_reg), m_imr);
      check(req, "eim_reg", int'(eim_reg), m_eim);
      check(req, "entry_req", int'(entry_req), int'(f_req(m_lines, m_eim, m_serviced)));
   endtask

   // Inputs already driven; advance model over one edge, then sample.
   task automatic step();
      if (entry_ack && m_lines != 0) begin
         m_eim = f_level(m_lines);
         m_serviced = 1;
      end else if ((rti_strobe || cleim_strobe) && hyper_mode) begin
         m_eim = m_imr;
         m_serviced = 0;
      end
      if (mask_wr_en) m_imr = int'(mask_wr_data[2:0]);
      m_lines = irq_lines;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [7:0] l, input bit wr, input logic [7:0] wd,
                        input bit ack, input bit rti, input bit clr, input bit hyp);
      irq_lines = l; mask_wr_en = wr; mask_wr_data = wd;
      entry_ack = ack; rti_strobe = rti; cleim_strobe = clr; hyper_mode = hyp;
   endtask

   initial begin
      #(8 * 200000);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      check("R3", "imr after reset", int'(imr_reg), 0);
      check("R3", "eim after reset", int'(eim_reg), 0);
      check("R2", "isr none code", int'(isr_reg), 7);
      check("R2", "no request idle", int'(entry_req), 0);

      // R1 lines 2,5,7 -> 2, masked (imr 0) so no request (R5)
      drive(8'b1010_0100, 0, 0, 0, 0, 0, 0); step();
      check("R1", "isr lowest line", int'(isr_reg), 2);
      check("R5", "masked line no req", int'(entry_req), 0);
      // R5 NMI always enabled with imr 0
      drive(8'b0000_0001, 0, 0, 0, 0, 0, 0); step();
      check("R5", "nmi request", int'(entry_req), 1);
      // R4 write mask 3 with junk upper bits; eim unchanged
      drive(8'b0000_1000, 1, 8'hFB, 0, 0, 0, 1); step();
      check("R4", "imr written", int'(imr_reg), 3);
      check("R4", "eim unchanged by write", int'(eim_reg), 0);
      check("R5", "line3 blocked by eim 0", int'(entry_req), 0);
      // R7 non-hyper return ignored
      drive(8'b0000_1000, 0, 0, 0, 1, 1, 0); step();
      check("R7", "user rti ignored", int'(eim_reg), 0);
      // R7 hyper clear reloads
      drive(8'b0000_1000, 0, 0, 0, 0, 1, 1); step();
      check("R7", "cleim reload", int'(eim_reg), 3);
      check("R5", "line3 inclusive req", int'(entry_req), 1);
      // R6 ack loads level 3, strict afterwards
      drive(8'b0000_1000, 0, 0, 1, 0, 0, 1); step();
      check("R6", "eim from isr", int'(eim_reg), 3);
      check("R6", "same level no nest", int'(entry_req), 0);
      drive(8'b0000_1010, 0, 0, 0, 0, 0, 1); step();
      check("R6", "higher level nests", int'(entry_req), 1);
      // R8 ack and rti together: ack wins
      drive(8'b0000_0010, 0, 0, 1, 1, 0, 1); step();
      check("R8", "ack wins", int'(eim_reg), 1);
      // R9 ack with no line active ignored
      drive(8'b0000_0000, 0, 0, 0, 0, 0, 1); step();
      drive(8'b0000_0000, 0, 0, 1, 0, 0, 1); step();
      check("R9", "ack idle ignored", int'(eim_reg), 1);
      check("R2", "isr_valid low idle", int'(isr_valid), 0);
      check_all("R9");

      // Random mix, all outputs compared each cycle
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] l;
         l = 8'($urandom);
         if ($urandom_range(0, 3) == 0) l = '0;
         else if ($urandom_range(0, 1) == 0) l = l & 8'hF0 | 8'(l[0]);
         drive(l, ($urandom_range(0, 7) == 0), 8'($urandom),
               ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
               ($urandom_range(0, 7) == 0), 1'($urandom));
         step();
         check_all("R1/R5/R6/R7/R8 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule